// File: doc/BRIEF.md
# Program Register File with Null Identifier

This block holds the architectural registers of a small processor. A 4-bit register identifier addresses it directly. It offers two independent read ports and one write port. All three can be used in the same cycle, and each port has its own identifier and data signals. Reads are purely combinational: the read data follows the identifier with no clock in between. A write changes the addressed register only at the rising clock edge.

The all-ones identifier (0xF) is reserved to mean "no register". With a 4-bit identifier, only fifteen storage registers exist. A read port given 0xF returns all zeros. A write given 0xF leaves every register untouched. Control logic uses this to idle any port without a separate enable.

Nothing is forwarded from the write port to the read ports within a cycle. A read of the register being written returns the value held before the edge. An active-low asynchronous reset clears all fifteen registers.

Top module: `prog_regfile`

## Requirements
- R1: While `rst_ni` is low, all fifteen registers are cleared to zero, and every read after reset returns zero until a write occurs.
- R2: When `wr_id_i` is not 0xF at a rising clock edge, the register numbered `wr_id_i` takes the value `wr_data_i`.
- R3: The read data on each port equals the contents of the register named by that port's identifier in the same cycle, with no clock edge needed after the identifier changes.
- R4: A read port whose identifier is 0xF outputs zero on every data bit, whatever the registers hold.
- R5: When `wr_id_i` is 0xF at a rising edge, no register changes, whatever `wr_data_i` holds.
- R6: A read of the register being written returns the old contents until the edge, and the new contents after it.
- R7: The two read ports are independent. They may name the same or different registers in one cycle, and each returns its own register's contents.
- R8: A write changes only the addressed register. All other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes occur on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_a_id_i | input | ID_W (4) | Read port A identifier; 0xF selects no register |
| rd_a_data_o | output | DATA_W (32) | Read port A data |
| rd_b_id_i | input | ID_W (4) | Read port B identifier; 0xF selects no register |
| rd_b_data_o | output | DATA_W (32) | Read port B data |
| wr_id_i | input | ID_W (4) | Write identifier; 0xF suppresses the write |
| wr_data_i | input | DATA_W (32) | Write data |

## Verification
The bench first fills all fifteen registers with distinct per-register patterns and reads them back on both ports. A decode fault that aliases two identifiers, or swaps the ports, then shows up as the wrong pattern. A second pass writes an all-ones value over a single register and rereads the full file, which separates a correct write enable from one that reaches the neighbouring registers. Reads and writes to the null identifier are made while every register holds nonzero data, so that a leak through 0xF cannot hide behind zeros. A read and a write of the same register are placed in one cycle to tell the old value from a forwarded one.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned RF_DATA_W_DEF = 32;
  localparam int unsigned RF_ID_W_DEF   = 4;

  // The reserved identifier is all ones at any identifier width.
  function automatic int unsigned rf_num_regs(input int unsigned id_w);
    return (1 << id_w) - 1;
  endfunction
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
  parameter int unsigned ID_W     = regfile_pkg::RF_ID_W_DEF,
  parameter int unsigned NUM_REGS = regfile_pkg::rf_num_regs(ID_W)
) (
  input  logic [ID_W-1:0]     wr_id_i,
  output logic [NUM_REGS-1:0] wr_en_o
);
  // The null identifier matches no slot, so it produces no enable.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign wr_en_o[g] = (wr_id_i == ID_W'(g));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DATA_W   = regfile_pkg::RF_DATA_W_DEF,
  parameter int unsigned NUM_REGS = 15
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REGS-1:0]              wr_en_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q <= '0;
      else if (wr_en_i[g]) q <= wr_data_i;
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DATA_W   = regfile_pkg::RF_DATA_W_DEF,
  parameter int unsigned ID_W     = regfile_pkg::RF_ID_W_DEF,
  parameter int unsigned NUM_REGS = regfile_pkg::rf_num_regs(ID_W)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [ID_W-1:0]                 rd_id_i,
  output logic [DATA_W-1:0]               rd_data_o
);
  localparam logic [ID_W-1:0] NULL_ID = '1;

  // AND-OR select: the null identifier matches no slot and yields zero.
  always_comb begin
    rd_data_o = '0;
    if (rd_id_i != NULL_ID) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (rd_id_i == ID_W'(i)) rd_data_o = rd_data_o | regs_i[i];
      end
    end
  end
endmodule

// File: rtl/prog_regfile.sv
module prog_regfile #(
  parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W_DEF,
  parameter int unsigned ID_W   = regfile_pkg::RF_ID_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   rd_a_id_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ID_W-1:0]   rd_b_id_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned NUM_REGS = regfile_pkg::rf_num_regs(ID_W);
  localparam int unsigned NUM_RD   = 2;

  logic [NUM_REGS-1:0]             wr_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][ID_W-1:0]     rd_id;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

  rf_write_decode #(.ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_dec (
    .wr_id_i (wr_id_i),
    .wr_en_o (wr_en)
  );

  rf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  assign rd_id[0] = rd_a_id_i;
  assign rd_id[1] = rd_b_id_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REGS(NUM_REGS)) u_rd (
      .regs_i    (regs),
      .rd_id_i   (rd_id[p]),
      .rd_data_o (rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: rtl/prog_regfile_chk.sv
module prog_regfile_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ID_W-1:0]   rd_a_id_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [ID_W-1:0]   rd_b_id_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic [ID_W-1:0]   wr_id_i,
  input logic [DATA_W-1:0] wr_data_i
);
  localparam logic [ID_W-1:0] NULL_ID = '1;

  p_null_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_id_i == NULL_ID) |-> (rd_a_data_o == '0));

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_id_i != NULL_ID) ##1 (rd_a_id_i == $past(wr_id_i))
      |-> (rd_a_data_o == $past(wr_data_i)));

  p_null_write_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_id_i == NULL_ID) ##1 $stable(rd_b_id_i) |-> $stable(rd_b_data_o));

  p_ports_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_id_i == rd_b_id_i) |-> (rd_a_data_o == rd_b_data_o));
endmodule

bind prog_regfile prog_regfile_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_a_id_i   (rd_a_id_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_id_i   (rd_b_id_i),
  .rd_b_data_o (rd_b_data_o),
  .wr_id_i     (wr_id_i),
  .wr_data_i   (wr_data_i)
);

// File: tb/prog_regfile_tb_top.sv
module prog_regfile_tb_top;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam logic [IW-1:0] NULL_ID = 4'hF;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] rd_a_id = '0, rd_b_id = '0, wr_id = NULL_ID;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic [DW-1:0] model [15];
  int            n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  prog_regfile #(.DATA_W(DW), .ID_W(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_a_id_i(rd_a_id), .rd_a_data_o(rd_a_data),
    .rd_b_id_i(rd_b_id), .rd_b_data_o(rd_b_data),
    .wr_id_i(wr_id), .wr_data_i(wr_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [IW-1:0] id, input logic [DW-1:0] d);
    @(negedge clk);
    wr_id = id; wr_data = d;
    @(negedge clk);
    wr_id = NULL_ID;
    if (id != NULL_ID) model[id] = d;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      rd_a_id = 4'(i); rd_b_id = 4'(14 - i);
      #1;
      check(req, rd_a_data, model[i]);
      check(req, rd_b_data, model[14 - i]);
    end
  endtask

  task automatic t_reset;  // R1
    for (int i = 0; i < 15; i++) model[i] = '0;
    read_all("R1");
  endtask

  task automatic t_fill;  // R2, R3
    for (int i = 0; i < 15; i++) do_write(4'(i), 32'hA5C3_0000 ^ (32'(i + 1) * 32'h0101_0111));
    read_all("R2");
  endtask

  task automatic t_isolation;  // R8
    do_write(4'd7, '1);
    read_all("R8");
    do_write(4'd0, 32'h0000_0001);
    do_write(4'd14, 32'h8000_0000);
    read_all("R8");
  endtask

  task automatic t_null_read;  // R4
    @(negedge clk);
    rd_a_id = NULL_ID; rd_b_id = NULL_ID;
    #1;
    check("R4", rd_a_data, '0);
    check("R4", rd_b_data, '0);
  endtask

  task automatic t_null_write;  // R5
    do_write(NULL_ID, 32'hDEAD_BEEF);
    do_write(NULL_ID, '1);
    read_all("R5");
  endtask

  task automatic t_same_cycle;  // R6
    @(negedge clk);
    wr_id = 4'd3; wr_data = 32'h1234_5678;
    rd_a_id = 4'd3; rd_b_id = 4'd3;
    #1;
    check("R6", rd_a_data, model[3]);
    check("R6", rd_b_data, model[3]);
    @(negedge clk);
    wr_id = NULL_ID;
    model[3] = 32'h1234_5678;
    #1;
    check("R6", rd_a_data, model[3]);
  endtask

  task automatic t_comb_read;  // R3, R7
    @(negedge clk);
    rd_a_id = 4'd5; rd_b_id = 4'd9;
    #1;
    check("R7", rd_a_data, model[5]);
    check("R7", rd_b_data, model[9]);
    #2;
    rd_a_id = 4'd11;  // no edge between
    #1;
    check("R3", rd_a_data, model[11]);
    check("R7", rd_b_data, model[9]);
  endtask

  task automatic t_reset_again;  // R1
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    for (int i = 0; i < 15; i++) model[i] = '0;
    rd_a_id = 4'd3; rd_b_id = 4'd7;
    #1;
    check("R1", rd_a_data, '0);
    check("R1", rd_b_data, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    read_all("R1");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_fill();
        t_isolation();
        t_null_read();
        t_null_write();
        t_same_cycle();
        t_comb_read();
        t_reset_again();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule